// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a small 32-bit RISC core. The set of registers that an instruction sees depends on the processor mode. A 5-bit mode input decides which physical copies stand behind r8–r14, and which saved status register can be reached. r0–r7 are common to every mode. The fast-interrupt mode owns private r8–r14. Each of the other four exception modes owns a private r13/r14 pair. System mode uses the user set. The store holds 37 physical 32-bit registers in total:

- 30 general registers
- the program counter
- the current status register
- five saved status registers

Two general read ports and one general write port serve r0–r14. The program counter has its own write port and a direct output. When r15 is read as an operand it yields the program counter plus 8. A user-view input lets a privileged handler read and write the user-mode copies without changing mode. All read data is registered. A read issued in one cycle appears after the next clock edge and shows the register contents from before any write at that same edge.

Top module: `bankreg_file`

## Requirements
- R1: While `rst` is high, each clock edge sets `pc_o` to 0, `cpsr_o` to 0x000000D3, both read data outputs to 0 and `spsr_rd_data_o` to 0.
- R2: A general read appears one clock edge after its index is presented. If a write to the same register happens at that edge, the read returns the value from before the write.
- R3: r0–r7 are one shared set in every mode.
- R4: In fast-interrupt mode (mode 5'b10001), r8–r14 are private copies, separate from the user copies.
- R5: Modes 5'b10010, 5'b10011, 5'b10111 and 5'b11011 each have a private r13 and r14, and share r8–r12 with user mode (5'b10000).
- R6: System mode (5'b11111) and any encoding not in the list above use the user register set.
- R7: Reading index 15 on either read port returns the program counter value at the read cycle plus 8.
- R8: The general write port with index 15 has no effect. `pc_wr_en_i` loads `pc_o` at the next edge.
- R9: With `user_view_i` high, both read ports and the write port reach the user copies of r8–r14, whatever the mode.
- R10: Each of the five exception modes has its own saved status register. A write goes to the current mode's copy, and a read returns that copy one edge later.
- R11: In user, system or unknown modes, `spsr_rd_data_o` returns 0 and a saved-status write changes no copy.
- R12: `cpsr_wr_en_i` loads `cpsr_o` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current processor mode |
| user_view_i | input | 1 | Steer general ports to the user copies |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data (registered) |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data (registered) |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | General write index (r0–r14) |
| wr_data_i | input | 32 | General write data |
| pc_wr_en_i | input | 1 | Program counter load |
| pc_wr_data_i | input | 32 | Program counter value to load |
| pc_o | output | 32 | Current program counter |
| cpsr_wr_en_i | input | 1 | Current status write enable |
| cpsr_wr_data_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status register |
| spsr_wr_en_i | input | 1 | Saved status write enable |
| spsr_wr_data_i | input | 32 | Saved status write data |
| spsr_rd_data_o | output | 32 | Saved status of current mode (registered) |

## Verification
The hardest case to reach is proof that one mode's write did not land in another mode's copy. Every banked copy looks the same from the ports until the mode is switched and the register is read again. The stimulus table first fills r13 with a distinct value in each of the six banks, and r8 in both of its banks. It then revisits each mode, including system and an unknown encoding, and reads the registers back. The user-view path is exercised the same way: a write is made through it in fast-interrupt mode, and the value is then read back in user mode.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  // Bank that backs r8-r14 and the saved status register
  typedef enum logic [2:0] {BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2,
                            BK_SVC = 3'd3, BK_ABT = 3'd4, BK_UND = 3'd5} bank_e;

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;

  localparam int LOW_CNT   = 8;                         // r0-r7 shared
  localparam int FIQ_CNT   = 5;                         // r8-r12 two copies
  localparam int BANK_CNT  = 6;                         // r13/r14 copies
  localparam int PAIR_BASE = LOW_CNT + 2 * FIQ_CNT;
  localparam int NPHYS     = PAIR_BASE + 2 * BANK_CNT;  // 30
  localparam int PA_W      = $clog2(NPHYS);
  localparam int NSAVED    = BANK_CNT - 1;

  function automatic bank_e bank_of(input logic [4:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;  // user, system and unknown encodings
    endcase
  endfunction
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  bank_e             bank_i,
  input  logic [3:0]        idx_i,
  output logic [PA_W-1:0]   paddr_o
);
  int tmp;
  always_comb begin
    if (int'(idx_i) < LOW_CNT)
      tmp = int'(idx_i);
    else if (int'(idx_i) < LOW_CNT + FIQ_CNT)
      tmp = (bank_i == BK_FIQ) ? int'(idx_i) + FIQ_CNT : int'(idx_i);
    else if (idx_i == 4'd15)
      tmp = 0;
    else
      tmp = PAIR_BASE + 2 * int'(bank_i) + (int'(idx_i) - (LOW_CNT + FIQ_CNT));
    paddr_o = PA_W'(tmp);
  end
endmodule

// File: rtl/bankreg_gpr.sv
module bankreg_gpr #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 30,
  parameter int AW    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/bankreg_psr.sv
module bankreg_psr
  import bankreg_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] CPSR_RST = 32'h0000_00D3
) (
  input  logic            clk,
  input  logic            rst,
  input  bank_e           bank_i,
  input  logic            pc_we,
  input  logic [XLEN-1:0] pc_wd,
  output logic [XLEN-1:0] pc_q,
  input  logic            cpsr_we,
  input  logic [XLEN-1:0] cpsr_wd,
  output logic [XLEN-1:0] cpsr_q,
  input  logic            spsr_we,
  input  logic [XLEN-1:0] spsr_wd,
  output logic [XLEN-1:0] spsr_rd
);
  logic [XLEN-1:0] saved [NSAVED];
  logic            has_saved;
  int              sidx;

  assign has_saved = (bank_i != BK_USR);
  assign sidx      = has_saved ? int'(bank_i) - 1 : 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      cpsr_q  <= CPSR_RST;
      spsr_rd <= '0;
    end else begin
      if (pc_we)   pc_q   <= pc_wd;
      if (cpsr_we) cpsr_q <= cpsr_wd;
      spsr_rd <= has_saved ? saved[sidx] : '0;
    end
  end

  for (genvar s = 0; s < NSAVED; s++) begin : g_saved
    always_ff @(posedge clk) begin
      if (rst)                                   saved[s] <= '0;
      else if (spsr_we && has_saved && sidx == s) saved[s] <= spsr_wd;
    end
  end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int PC_AHEAD = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      mode_i,
  input  logic            user_view_i,
  input  logic [3:0]      rd_a_idx_i,
  output logic [XLEN-1:0] rd_a_data_o,
  input  logic [3:0]      rd_b_idx_i,
  output logic [XLEN-1:0] rd_b_data_o,
  input  logic            wr_en_i,
  input  logic [3:0]      wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            pc_wr_en_i,
  input  logic [XLEN-1:0] pc_wr_data_i,
  output logic [XLEN-1:0] pc_o,
  input  logic            cpsr_wr_en_i,
  input  logic [XLEN-1:0] cpsr_wr_data_i,
  output logic [XLEN-1:0] cpsr_o,
  input  logic            spsr_wr_en_i,
  input  logic [XLEN-1:0] spsr_wr_data_i,
  output logic [XLEN-1:0] spsr_rd_data_o
);
  localparam int NRD = 2;

  bank_e             mode_bank, gpr_bank;
  logic [PA_W-1:0]   wpa;
  logic              gpr_we;
  logic [3:0]        ridx  [NRD];
  logic [XLEN-1:0]   rdout [NRD];

  assign mode_bank = bank_of(mode_i);
  assign gpr_bank  = user_view_i ? BK_USR : mode_bank;
  assign gpr_we    = wr_en_i && (wr_idx_i != 4'd15);
  assign ridx[0]   = rd_a_idx_i;
  assign ridx[1]   = rd_b_idx_i;

  bankreg_map u_wmap (.bank_i(gpr_bank), .idx_i(wr_idx_i), .paddr_o(wpa));

  // One storage copy per read port, all written together
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [PA_W-1:0] rpa;
    logic [XLEN-1:0] mem_q, pc8_q;
    logic            is15_q;

    bankreg_map u_rmap (.bank_i(gpr_bank), .idx_i(ridx[p]), .paddr_o(rpa));

    bankreg_gpr #(.XLEN(XLEN), .DEPTH(NPHYS), .AW(PA_W)) u_copy (
      .clk(clk), .rst(rst), .we(gpr_we), .waddr(wpa), .wdata(wr_data_i),
      .raddr(rpa), .rdata(mem_q)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        is15_q <= 1'b0;
        pc8_q  <= '0;
      end else begin
        is15_q <= (ridx[p] == 4'd15);
        pc8_q  <= pc_o + XLEN'(PC_AHEAD);
      end
    end

    assign rdout[p] = is15_q ? pc8_q : mem_q;
  end

  assign rd_a_data_o = rdout[0];
  assign rd_b_data_o = rdout[1];

  bankreg_psr #(.XLEN(XLEN)) u_psr (
    .clk(clk), .rst(rst), .bank_i(mode_bank),
    .pc_we(pc_wr_en_i), .pc_wd(pc_wr_data_i), .pc_q(pc_o),
    .cpsr_we(cpsr_wr_en_i), .cpsr_wd(cpsr_wr_data_i), .cpsr_q(cpsr_o),
    .spsr_we(spsr_wr_en_i), .spsr_wd(spsr_wr_data_i), .spsr_rd(spsr_rd_data_o)
  );
endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk
  import bankreg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [4:0]      mode_i,
  input logic [3:0]      rd_a_idx_i,
  input logic [XLEN-1:0] rd_a_data_o,
  input logic            wr_en_i,
  input logic [3:0]      wr_idx_i,
  input logic            pc_wr_en_i,
  input logic [XLEN-1:0] pc_wr_data_i,
  input logic [XLEN-1:0] pc_o,
  input logic            cpsr_wr_en_i,
  input logic [XLEN-1:0] cpsr_wr_data_i,
  input logic [XLEN-1:0] cpsr_o,
  input logic [XLEN-1:0] spsr_rd_data_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && spsr_rd_data_o == '0 && rd_a_data_o == '0));

  // R7
  pc_operand_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx_i == 4'd15 |=> rd_a_data_o == XLEN'($past(pc_o) + 8));

  // R8
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr_en_i |=> pc_o == $past(pc_wr_data_i));

  // R8
  r15_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_idx_i == 4'd15 && !pc_wr_en_i) |=> $stable(pc_o));

  // R11
  no_saved_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_of(mode_i) == BK_USR) |=> spsr_rd_data_o == '0);

  // R12
  cpsr_load_chk: assert property (@(posedge clk) disable iff (rst)
    cpsr_wr_en_i |=> cpsr_o == $past(cpsr_wr_data_i));
endmodule

bind bankreg_file bankreg_file_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .rd_a_idx_i(rd_a_idx_i),
  .rd_a_data_o(rd_a_data_o), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
  .pc_wr_en_i(pc_wr_en_i), .pc_wr_data_i(pc_wr_data_i), .pc_o(pc_o),
  .cpsr_wr_en_i(cpsr_wr_en_i), .cpsr_wr_data_i(cpsr_wr_data_i),
  .cpsr_o(cpsr_o), .spsr_rd_data_o(spsr_rd_data_o)
);

// File: tb/bankreg_file_test.sv
module bankreg_file_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode_i = 5'b10000;
  logic        user_view_i = 1'b0;
  logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic        wr_en_i = 1'b0, pc_wr_en_i = 1'b0, cpsr_wr_en_i = 1'b0, spsr_wr_en_i = 1'b0;
  logic [31:0] pc_wr_data_i = '0, pc_o, cpsr_wr_data_i = '0, cpsr_o;
  logic [31:0] spsr_wr_data_i = '0, spsr_rd_data_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bankreg_file uut (.*);

  localparam logic [4:0] U = 5'b10000, F = 5'b10001, I = 5'b10010, S = 5'b10011,
                         A = 5'b10111, D = 5'b11011, Y = 5'b11111, X = 5'b00101;

  typedef struct packed {
    logic [4:0]  md; logic uv; logic we; logic [3:0] wi; logic [31:0] wd;
    logic [3:0]  ri; logic ck; logic [31:0] ex; logic [7:0] req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VT [NV] = '{
    '{U,0,1,4'd0, 32'h0A00,4'd0, 0,32'h0,    8'd3},
    '{U,0,1,4'd8, 32'h0108,4'd0, 0,32'h0,    8'd4},
    '{U,0,1,4'd13,32'h010D,4'd0, 0,32'h0,    8'd5},
    '{U,0,1,4'd14,32'h010E,4'd0, 0,32'h0,    8'd5},
    '{F,0,1,4'd8, 32'h0F08,4'd0, 0,32'h0,    8'd4},
    '{F,0,1,4'd13,32'h0F0D,4'd0, 0,32'h0,    8'd4},
    '{I,0,1,4'd13,32'h020D,4'd0, 0,32'h0,    8'd5},
    '{S,0,1,4'd13,32'h030D,4'd0, 0,32'h0,    8'd5},
    '{A,0,1,4'd13,32'h040D,4'd0, 0,32'h0,    8'd5},
    '{D,0,1,4'd13,32'h050D,4'd0, 0,32'h0,    8'd5},
    '{I,0,1,4'd14,32'h020E,4'd0, 0,32'h0,    8'd5},
    '{F,0,0,4'd0, 32'h0,   4'd0, 1,32'h0A00, 8'd3},  // R3
    '{F,0,0,4'd0, 32'h0,   4'd8, 1,32'h0F08, 8'd4},  // R4
    '{U,0,0,4'd0, 32'h0,   4'd8, 1,32'h0108, 8'd4},  // R4
    '{I,0,0,4'd0, 32'h0,   4'd8, 1,32'h0108, 8'd5},  // R5
    '{I,0,0,4'd0, 32'h0,   4'd13,1,32'h020D, 8'd5},  // R5
    '{S,0,0,4'd0, 32'h0,   4'd13,1,32'h030D, 8'd5},
    '{A,0,0,4'd0, 32'h0,   4'd13,1,32'h040D, 8'd5},
    '{D,0,0,4'd0, 32'h0,   4'd13,1,32'h050D, 8'd5},
    '{Y,0,0,4'd0, 32'h0,   4'd13,1,32'h010D, 8'd6},  // R6
    '{X,0,0,4'd0, 32'h0,   4'd13,1,32'h010D, 8'd6},  // R6
    '{F,0,0,4'd0, 32'h0,   4'd13,1,32'h0F0D, 8'd4},
    '{I,0,0,4'd0, 32'h0,   4'd14,1,32'h020E, 8'd5},
    '{U,0,0,4'd0, 32'h0,   4'd14,1,32'h010E, 8'd5},
    '{I,1,0,4'd0, 32'h0,   4'd13,1,32'h010D, 8'd9},  // R9
    '{F,1,0,4'd0, 32'h0,   4'd8, 1,32'h0108, 8'd9},
    '{F,1,1,4'd9, 32'h0109,4'd8, 1,32'h0108, 8'd9},
    '{U,0,0,4'd0, 32'h0,   4'd9, 1,32'h0109, 8'd9},
    '{U,0,1,4'd0, 32'h0B00,4'd0, 1,32'h0A00, 8'd2},  // R2 old value
    '{U,0,0,4'd0, 32'h0,   4'd0, 1,32'h0B00, 8'd2}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 0; pc_wr_en_i = 0; cpsr_wr_en_i = 0; spsr_wr_en_i = 0; user_view_i = 0;
  endtask

  task automatic spsr_put(input logic [4:0] m, input logic [31:0] v);
    mode_i = m; spsr_wr_en_i = 1; spsr_wr_data_i = v;
    @(negedge clk); spsr_wr_en_i = 0;
  endtask

  task automatic spsr_get(input string req, input logic [4:0] m, input logic [31:0] exp);
    mode_i = m;
    @(negedge clk); check(req, spsr_rd_data_o, exp);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pc", pc_o, 32'h0);
    check("R1 cpsr", cpsr_o, 32'h0000_00D3);
    check("R1 rd_a", rd_a_data_o, 32'h0);
    check("R1 rd_b", rd_b_data_o, 32'h0);
    check("R1 spsr", spsr_rd_data_o, 32'h0);
    rst = 0;

    // table walk: drive at negedge, result visible at following negedge
    for (int v = 0; v < NV; v++) begin
      mode_i = VT[v].md; user_view_i = VT[v].uv; wr_en_i = VT[v].we;
      wr_idx_i = VT[v].wi; wr_data_i = VT[v].wd;
      rd_a_idx_i = VT[v].ri; rd_b_idx_i = VT[v].ri;
      @(negedge clk);
      if (VT[v].ck) begin
        check($sformatf("R%0d vec%0d port A", VT[v].req, v), rd_a_data_o, VT[v].ex);
        check($sformatf("R%0d vec%0d port B", VT[v].req, v), rd_b_data_o, VT[v].ex);
      end
    end
    idle();

    // R8 program counter load
    pc_wr_en_i = 1; pc_wr_data_i = 32'h100;
    @(negedge clk); pc_wr_en_i = 0;
    check("R8 pc load", pc_o, 32'h100);
    // R7 r15 operand read on both ports
    rd_a_idx_i = 4'd15; rd_b_idx_i = 4'd15;
    @(negedge clk);
    check("R7 port A", rd_a_data_o, 32'h108);
    check("R7 port B", rd_b_data_o, 32'h108);
    // R7 with same-cycle pc load: old pc + 8
    pc_wr_en_i = 1; pc_wr_data_i = 32'h200;
    @(negedge clk); pc_wr_en_i = 0;
    check("R7 same-cycle", rd_a_data_o, 32'h108);
    @(negedge clk);
    check("R7 after load", rd_a_data_o, 32'h208);
    // R8 general write to index 15 ignored
    wr_en_i = 1; wr_idx_i = 4'd15; wr_data_i = 32'hDEAD_BEEF;
    @(negedge clk); wr_en_i = 0;
    @(negedge clk);
    check("R8 r15 write ignored pc", pc_o, 32'h200);
    check("R8 r15 write ignored read", rd_a_data_o, 32'h208);
    rd_a_idx_i = 4'd0; rd_b_idx_i = 4'd0;

    // R10 saved status per exception mode
    spsr_put(F, 32'h11); spsr_put(I, 32'h22); spsr_put(S, 32'h33);
    spsr_put(A, 32'h44); spsr_put(D, 32'h55);
    spsr_get("R10 fiq", F, 32'h11);
    spsr_get("R10 irq", I, 32'h22);
    spsr_get("R10 svc", S, 32'h33);
    spsr_get("R10 abt", A, 32'h44);
    spsr_get("R10 und", D, 32'h55);
    // R11 user/system: reads zero, writes land nowhere
    spsr_put(U, 32'h99); spsr_put(Y, 32'h98);
    spsr_get("R11 user", U, 32'h0);
    spsr_get("R11 system", Y, 32'h0);
    spsr_get("R11 unknown", X, 32'h0);
    spsr_get("R11 fiq intact", F, 32'h11);
    spsr_get("R11 irq intact", I, 32'h22);
    spsr_get("R11 und intact", D, 32'h55);

    // R12 current status load
    cpsr_wr_en_i = 1; cpsr_wr_data_i = 32'h0000_001F;
    @(negedge clk); cpsr_wr_en_i = 0;
    check("R12 cpsr", cpsr_o, 32'h0000_001F);

    // R1 reset again after activity
    rst = 1;
    @(negedge clk);
    check("R1 pc after rerun", pc_o, 32'h0);
    check("R1 cpsr after rerun", cpsr_o, 32'h0000_00D3);
    rst = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule